// File: doc/BRIEF.md
# Packet Error Interrupt Register Slice

This block sits beside a packet receiver and turns its raw error indication into a firmware-friendly interrupt. The receiver drives a status line that stays high for as long as the current packet is known to be bad. That line always falls for at least one cycle when a new packet starts. The block keeps a sticky event flag, a mask bit and a live copy of the status. It also drives a pending output that a higher-level interrupt collector can OR with other sources.

Software reaches the slice through a plain synchronous register port: an address, a write strobe, write data and combinational read data. Every register holds one bit, in bit 0 of the data word. By default the event flag is armed by a rising edge of the status, so firmware can clear it while the status is still high and still catch the next bad packet. A synthesis-time parameter selects level capture instead. In level mode the flag is set on every cycle the status is high.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `err_irq_csr`

## Requirements
- R1: While reset is asserted, and right after it is released, the mask bit, the event flag and the pending output are 0. Reads of offsets 0x0, 0x2 and 0x3 return 0.
- R2: A write to offset 0x2 loads bit 0 of the write data into the mask bit (1 unmasks, 0 masks). Reading offset 0x2 returns the mask bit in bit 0.
- R3: A write to offset 0x3 with data bit 0 set clears the event flag on that clock edge, unless a capture happens in the same cycle. A write with data bit 0 clear has no effect. Otherwise the flag holds its value. Reading offset 0x3 returns the flag in bit 0.
- R4: In edge mode (the default), the event flag is set on a clock edge where the status is 1 and was 0 on the previous edge. A status that stays high does not set the flag again after it has been cleared.
- R5: In edge mode, errored packets that are separated by a single low cycle of the status each set the event flag.
- R6: When a capture and a write-1 clear of the event flag fall in the same cycle, the flag ends up set.
- R7: The pending output, which is also readable at offset 0x0 bit 0, is 1 exactly when both the event flag and the mask bit are 1.
- R8: Reading offset 0x1 returns the current status input in bit 0, with no register delay.
- R9: Writes to offsets 0x0, 0x1 and to any offset above 0x3 change no state. Reads of offsets above 0x3 return 0, and read data bits above bit 0 are always 0.
- R10: If the status is already high when reset is released, that is not taken as a capture. The first clock edge after release never sets the event flag.
- R11: In level mode, the event flag is set on every clock edge after the first one following release at which the status is 1. It therefore comes back on the edge right after a clear if the status is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_status | input | 1 | Raw error status from the receiver datapath |
| reg_addr | input | ADDR_W | Register offset for reads and writes |
| reg_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | DATA_W | Write data; only bit 0 is used |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| irq_pending | output | 1 | Unmasked pending interrupt summary |

## Verification
A corrupted event flag or mask shows at the ports on the edge after the cause. It appears in the pending output and in the readback at offsets 0x0, 0x2 and 0x3, all sampled half a cycle later. A history flop that holds the wrong value only becomes visible when the status makes, or fails to make, a low-to-high step. For that reason the stimulus keeps toggling the status around clears. An edge-mode and a level-mode instance are compared against separate expected states, so a swapped capture rule shows up within one cycle of the status staying high after a clear.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;
  // Offsets with a fixed meaning for the read/write decode
  localparam int unsigned OFF_PEND = 0;
  localparam int unsigned OFF_STAT = 1;
  localparam int unsigned OFF_MASK = 2;
  localparam int unsigned OFF_EVT  = 3;

  typedef enum logic [1:0] {
    CAP_EDGE  = 2'd0,
    CAP_LEVEL = 2'd1
  } cap_mode_e;
endpackage

// File: rtl/err_evt_capture.sv
module err_evt_capture
  import err_irq_pkg::*;
#(
  parameter cap_mode_e MODE = CAP_EDGE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic status,
  output logic capture
);
  logic hist_q;
  logic primed_q;

  // One history flop for the previous status value, plus a primed flag
  // so a status already high at reset release is not a new event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      hist_q   <= status;
      primed_q <= 1'b1;
    end
  end

  generate
    if (MODE == CAP_EDGE) begin : g_edge
      assign capture = status & ~hist_q & primed_q;
    end else begin : g_level
      logic unused_hist;
      assign unused_hist = hist_q;
      assign capture = status & primed_q;
    end
  endgenerate
endmodule

// File: rtl/err_irq_regs.sv
module err_irq_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic mask_wr,
  input  logic mask_wbit,
  input  logic evt_clr,
  output logic mask_q,
  output logic evt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
    end else if (mask_wr) begin
      mask_q <= mask_wbit;
    end
  end

  // A capture takes priority over a clear, so no event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
    end else if (capture) begin
      evt_q <= 1'b1;
    end else if (evt_clr) begin
      evt_q <= 1'b0;
    end
  end
endmodule

// File: rtl/err_irq_rdmux.sv
module err_irq_rdmux
  import err_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              pend,
  input  logic              stat,
  input  logic              mask,
  input  logic              evt,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PAD_W = DATA_W - 1;

  logic bit0;

  always_comb begin
    bit0 = 1'b0;
    if (addr == ADDR_W'(OFF_PEND))      bit0 = pend;
    else if (addr == ADDR_W'(OFF_STAT)) bit0 = stat;
    else if (addr == ADDR_W'(OFF_MASK)) bit0 = mask;
    else if (addr == ADDR_W'(OFF_EVT))  bit0 = evt;
  end

  assign rdata = {{PAD_W{1'b0}}, bit0};
endmodule

// File: rtl/err_irq_csr.sv
module err_irq_csr
  import err_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter cap_mode_e   MODE   = CAP_EDGE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_status,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pending
);
  logic capture;
  logic mask_wr;
  logic evt_clr;
  logic mask_q;
  logic evt_q;
  logic wbit;

  assign wbit    = reg_wdata[0];
  assign mask_wr = reg_wr_en && (reg_addr == ADDR_W'(OFF_MASK));
  assign evt_clr = reg_wr_en && (reg_addr == ADDR_W'(OFF_EVT)) && wbit;

  err_evt_capture #(.MODE(MODE)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (err_status),
    .capture (capture)
  );

  err_irq_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .mask_wr   (mask_wr),
    .mask_wbit (wbit),
    .evt_clr   (evt_clr),
    .mask_q    (mask_q),
    .evt_q     (evt_q)
  );

  assign irq_pending = evt_q & mask_q;

  err_irq_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .addr  (reg_addr),
    .pend  (irq_pending),
    .stat  (err_status),
    .mask  (mask_q),
    .evt   (evt_q),
    .rdata (reg_rdata)
  );
endmodule

// File: rtl/err_irq_csr_chk.sv
module err_irq_csr_chk
  import err_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter cap_mode_e   MODE   = CAP_EDGE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_status,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr_en,
  input logic              wbit,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_pending,
  input logic              capture,
  input logic              mask_q,
  input logic              evt_q
);
  logic c_mask_wr;
  logic c_clr;
  assign c_mask_wr = reg_wr_en && (reg_addr == ADDR_W'(OFF_MASK));
  assign c_clr     = reg_wr_en && (reg_addr == ADDR_W'(OFF_EVT)) && wbit;

  assert_pend_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending) |-> ($past(capture) || $past(c_mask_wr && wbit)));

  assert_capture_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> evt_q);

  assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && c_clr) |=> evt_q);

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_clr && !capture) |=> !evt_q);

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q && !c_clr) |=> evt_q);

  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_q && !capture) |=> !evt_q);

  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !c_mask_wr |=> $stable(mask_q));

  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c_mask_wr |=> (mask_q == $past(wbit)));

  assert_rd_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rdata >> 1) == '0));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > ADDR_W'(OFF_EVT)) |-> (reg_rdata == '0));

  generate
    if (MODE == CAP_EDGE) begin : g_edge_chk
      assert_edge_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (err_status && !$past(err_status)));
    end else begin : g_level_chk
      assert_level_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> err_status);
    end
  endgenerate
endmodule

bind err_irq_csr err_irq_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE(MODE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .err_status  (err_status),
  .reg_addr    (reg_addr),
  .reg_wr_en   (reg_wr_en),
  .wbit        (wbit),
  .reg_rdata   (reg_rdata),
  .irq_pending (irq_pending),
  .capture     (capture),
  .mask_q      (mask_q),
  .evt_q       (evt_q)
);

// File: tb/tb_err_irq_csr.sv
`timescale 1ns/1ps
module tb_err_irq_csr;
  import err_irq_pkg::*;

  localparam int unsigned AW = 4;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          s = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rd_e, rd_l;
  logic          pend_e, pend_l;

  int total = 0;
  int fails = 0;

  // expected state
  logic hist_m, primed_m, mask_m, evt_e, evt_l;

  always #2 clk = ~clk;

  err_irq_csr #(.ADDR_W(AW), .DATA_W(DW), .MODE(CAP_EDGE)) dut (
    .clk(clk), .rst_n(rst_n), .err_status(s), .reg_addr(addr), .reg_wr_en(wr),
    .reg_wdata(wd), .reg_rdata(rd_e), .irq_pending(pend_e));

  err_irq_csr #(.ADDR_W(AW), .DATA_W(DW), .MODE(CAP_LEVEL)) dut_lvl (
    .clk(clk), .rst_n(rst_n), .err_status(s), .reg_addr(addr), .reg_wr_en(wr),
    .reg_wdata(wd), .reg_rdata(rd_l), .irq_pending(pend_l));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a, input logic ev);
    logic [DW-1:0] r;
    r = '0;
    case (a)
      AW'(OFF_PEND): r[0] = ev & mask_m;
      AW'(OFF_STAT): r[0] = s;
      AW'(OFF_MASK): r[0] = mask_m;
      AW'(OFF_EVT):  r[0] = ev;
      default:       r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a);
    case (a)
      AW'(OFF_PEND): return "R7";
      AW'(OFF_STAT): return "R8";
      AW'(OFF_MASK): return "R2";
      AW'(OFF_EVT):  return "R3";
      default:       return "R9";
    endcase
  endfunction

  task automatic compare_now(input string req);
    chk({req, " edge rdata"}, rd_e, exp_rd(addr, evt_e));
    chk({req, " level rdata R11"}, rd_l, exp_rd(addr, evt_l));
    chk("R7 edge pending", {{(DW-1){1'b0}}, pend_e}, {{(DW-1){1'b0}}, evt_e & mask_m});
    chk("R7 level pending", {{(DW-1){1'b0}}, pend_l}, {{(DW-1){1'b0}}, evt_l & mask_m});
  endtask

  // Drive one cycle at the falling edge, check, then advance the model.
  task automatic cyc(input logic st, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic cap_e, cap_l, clr;
    s = st; wr = w; addr = a; wd = d;
    #1;
    compare_now(tag_of(a));
    cap_e = primed_m & s & ~hist_m;
    cap_l = primed_m & s;
    clr   = wr && (addr == AW'(OFF_EVT)) && wd[0];
    @(posedge clk);
    if (wr && (addr == AW'(OFF_MASK))) mask_m = wd[0];
    evt_e    = cap_e | (evt_e & ~clr);
    evt_l    = cap_l | (evt_l & ~clr);
    hist_m   = st;
    primed_m = 1'b1;
    @(negedge clk);
  endtask

  // Read without writing or clocking
  task automatic peek(input logic [AW-1:0] a, input string req);
    wr = 1'b0; addr = a;
    #1;
    compare_now(req);
  endtask

  initial begin
    #(4 * 200000);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    hist_m = 0; primed_m = 0; mask_m = 0; evt_e = 0; evt_l = 0;
    // Reset with status held high (R10)
    s = 1'b1;
    repeat (3) @(negedge clk);
    peek(AW'(OFF_EVT), "R1");
    peek(AW'(OFF_MASK), "R1");
    peek(AW'(OFF_PEND), "R1");
    rst_n = 1'b1;
    cyc(1'b1, 1'b0, AW'(OFF_EVT), '0);
    chk("R10 edge event after release", {7'd0, evt_e}, 8'd0);
    peek(AW'(OFF_EVT), "R10");
    cyc(1'b1, 1'b0, AW'(OFF_EVT), '0);
    peek(AW'(OFF_EVT), "R10");
    // Clear anything level mode caught, then rise (R4)
    cyc(1'b0, 1'b1, AW'(OFF_EVT), 8'h01);
    cyc(1'b1, 1'b0, AW'(OFF_EVT), '0);
    peek(AW'(OFF_EVT), "R4");
    chk("R4 edge event set", rd_e, 8'h01);
    // Unmask (R2) and see pending (R7)
    cyc(1'b1, 1'b1, AW'(OFF_MASK), 8'hFF);
    peek(AW'(OFF_PEND), "R7");
    chk("R7 pending asserted", {7'd0, pend_e}, 8'd1);
    // Clear while status stays high (R3, R11)
    cyc(1'b1, 1'b1, AW'(OFF_EVT), 8'h01);
    peek(AW'(OFF_EVT), "R3");
    chk("R3 edge event cleared", rd_e, 8'h00);
    chk("R11 level event reasserted", rd_l, 8'h01);
    cyc(1'b1, 1'b1, AW'(OFF_EVT), 8'h00);
    peek(AW'(OFF_EVT), "R3");
    // Rise and clear in the same cycle (R6)
    cyc(1'b0, 1'b0, AW'(OFF_EVT), '0);
    cyc(1'b1, 1'b1, AW'(OFF_EVT), 8'h01);
    peek(AW'(OFF_EVT), "R6");
    chk("R6 set beats clear", rd_e, 8'h01);
    // Back-to-back errored packets (R5)
    cyc(1'b1, 1'b1, AW'(OFF_EVT), 8'h01);
    cyc(1'b0, 1'b0, AW'(OFF_STAT), '0);
    cyc(1'b1, 1'b0, AW'(OFF_STAT), '0);
    peek(AW'(OFF_EVT), "R5");
    chk("R5 second packet captured", rd_e, 8'h01);
    // Writes to read-only and unmapped offsets (R9)
    cyc(1'b0, 1'b1, AW'(OFF_PEND), 8'h00);
    cyc(1'b0, 1'b1, AW'(OFF_STAT), 8'h00);
    cyc(1'b0, 1'b1, AW'(9), 8'h00);
    peek(AW'(9), "R9");
    chk("R9 unmapped read zero", rd_e, 8'h00);
    peek(AW'(OFF_MASK), "R9");
    chk("R9 mask untouched", rd_e, 8'h01);
    peek(AW'(OFF_STAT), "R8");
    // Constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic st, w;
      logic [AW-1:0] a;
      st = ($urandom_range(0, 3) == 0) ? ~s : s;
      w  = ($urandom_range(0, 2) == 0);
      a  = ($urandom_range(0, 5) == 0) ? AW'($urandom_range(0, 15)) : AW'($urandom_range(0, 3));
      cyc(st, w, a, DW'($urandom));
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule